// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Permission Check

This block caches page table entries for a memory management unit. Each entry holds a virtual page number as its tag and a whole page table entry as its value: a present flag, read, write and execute permissions, and a physical frame number. An access request carries a virtual address and an access kind. Every entry is compared against the request's page number in the same cycle. The registered response is one of three outcomes: a translation, a protection fault, or a miss. A translation is the cached frame number joined to the untranslated 12-bit page offset.

An external table walker services misses. It writes entries back through a refill port. Software keeps the buffer consistent with the page tables in two ways. It invalidates a single page after that page's protection changes. It flushes every entry on a context switch. When a refill finds the buffer full, a not-recently-used policy picks the entry to replace. Each entry has a referenced flag for this policy.

Top module: `xlat_tlb`

## Requirements
- R1: The response to a lookup (`lk_valid` high in cycle N) appears in cycle N+1, with `rsp_valid` high. In a cycle after no lookup, `rsp_valid`, `rsp_miss` and `rsp_fault` are all low.
- R2: On an allowed hit, `rsp_paddr` equals the cached frame number in the upper bits followed by `lk_vaddr[11:0]`. Both `rsp_miss` and `rsp_fault` are low.
- R3: Access kinds are encoded 00 read, 01 write, 10 execute and 11 reserved. A hit raises `rsp_fault` with `rsp_paddr` zero in three cases: the present flag is clear, the needed permission flag is clear, or the kind is 11.
- R4: A lookup whose page number matches no valid entry raises `rsp_miss` with `rsp_paddr` zero.
- R5: `fill_pte` has bit 0 present, bit 1 read, bit 2 write, bit 3 execute, and bits [PFN+3:4] the frame number. A refill in cycle N is visible to lookups from cycle N+1.
- R6: A refill whose page number is already cached overwrites that entry. No duplicate is created, and the buffer never holds two valid entries with one tag.
- R7: Invalidating a page removes only that page's entry. Invalidating an uncached page changes nothing.
- R8: A flush removes every entry. It also clears every referenced flag.
- R9: Flush has priority over invalidate, and invalidate has priority over refill. A refill in the same cycle as either one is dropped.
- R10: A lookup made in the same cycle as a refill, invalidate or flush sees the contents from before that operation.
- R11: A refill of a new page uses the lowest-numbered free entry if any entry is free.
- R12: A refill into a full buffer replaces the lowest-numbered entry whose referenced flag is clear. A lookup that matches an entry sets that entry's flag, and so does a refill that writes it. When an update would leave all flags set, only the flags touched in that cycle are kept.
- R13: After reset the buffer is empty and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind (00 read, 01 write, 10 execute) |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | VA_W-OFF_W | Page number being refilled |
| fill_pte | input | PA_W-OFF_W+4 | Page table entry being refilled |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vpn | input | VA_W-OFF_W | Page number to invalidate |
| flush | input | 1 | Remove all entries |
| rsp_valid | output | 1 | Response present |
| rsp_miss | output | 1 | No entry for the page |
| rsp_fault | output | 1 | Entry found but access not permitted |
| rsp_paddr | output | PA_W | Translated physical address, zero unless translated |

## Verification
Every lookup response is due exactly one clock edge after the request, because all result flags and the frame read are registered once. The bench therefore applies stimulus on the falling edge and compares outputs on the next falling edge. Maintenance operations take effect at the edge that ends their cycle. The bench's model applies a cycle's lookup against the old contents and only then applies that cycle's maintenance, which matches the same-cycle ordering. A small four-entry configuration is used, so the replacement sweep fills, saturates and evicts many times. The sweep mixes lookups with refills, invalidates and flushes in the same cycle.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int PTE_PRESENT = 0;
  localparam int PTE_RD      = 1;
  localparam int PTE_WR      = 2;
  localparam int PTE_EX      = 3;
  localparam int PTE_FLAGS   = 4;

  function automatic logic perm_ok(input logic [PTE_FLAGS-1:0] flg, input acc_kind_e kind);
    logic ok;
    case (kind)
      ACC_LOAD:  ok = flg[PTE_RD];
      ACC_STORE: ok = flg[PTE_WR];
      ACC_FETCH: ok = flg[PTE_EX];
      default:   ok = 1'b0;
    endcase
    return ok & flg[PTE_PRESENT];
  endfunction

endpackage

// File: rtl/xlat_tlb_tags.sv
module xlat_tlb_tags #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 5,
  parameter int FLG_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [VPN_W-1:0]   mnt_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [FLG_W-1:0]   wr_flags,
  input  logic               inv_en,
  input  logic               flush,
  output logic [ENTRIES-1:0] lk_match,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [FLG_W-1:0]   lk_flags,
  output logic [ENTRIES-1:0] mnt_match,
  output logic [IDX_W-1:0]   mnt_idx,
  output logic [ENTRIES-1:0] occ
);

  logic [FLG_W-1:0] flg_m [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             vld_r;
    logic [VPN_W-1:0] tag_r;
    logic [FLG_W-1:0] flg_r;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || flush)                 vld_r <= 1'b0;
      else if (inv_en && mnt_match[g])  vld_r <= 1'b0;
      else if (sel)                     vld_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_r <= wr_vpn;
        flg_r <= wr_flags;
      end
    end

    assign occ[g]       = vld_r;
    assign lk_match[g]  = vld_r && (tag_r == lk_vpn);
    assign mnt_match[g] = vld_r && (tag_r == mnt_vpn);
    assign flg_m[g]     = lk_match[g] ? flg_r : '0;
  end

  always_comb begin
    lk_flags = '0;
    lk_idx   = '0;
    mnt_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_flags = lk_flags | flg_m[i];
      if (lk_match[i])  lk_idx  = lk_idx  | IDX_W'(i);
      if (mnt_match[i]) mnt_idx = mnt_idx | IDX_W'(i);
    end
  end

  // R6: refills never create a second entry with the same tag
  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R5: a refill lands in the selected slot by the next cycle
  p_fill_lands_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> occ[$past(wr_idx)]);

  // R7: an invalidated page's slot is empty afterwards
  p_inv_removes_r7: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> ((occ & $past(mnt_match)) == '0));

  // R8: a flush empties every slot
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0));

endmodule

// File: rtl/xlat_tlb_nru.sv
module xlat_tlb_nru #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] occ,
  input  logic [ENTRIES-1:0] touch,
  input  logic [ENTRIES-1:0] clr,
  output logic [IDX_W-1:0]   victim
);

  logic [ENTRIES-1:0] ref_q;
  logic [ENTRIES-1:0] ref_d;
  logic [ENTRIES-1:0] merged;

  always_comb begin
    merged = (ref_q | touch) & ~clr;
    ref_d  = (&merged) ? (touch & ~clr) : merged;
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else     ref_q <= ref_d;
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !occ[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !ref_q[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  if (ENTRIES > 1) begin : g_chk
    // R12: the referenced flags never all stay set
    p_ref_not_saturated_r12: assert property (@(posedge clk) disable iff (rst)
      !(&ref_q));
  end

endmodule

// File: rtl/xlat_tlb_pfn_ram.sv
module xlat_tlb_pfn_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 20,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            lk_valid,
  input  logic [VA_W-1:0]                 lk_vaddr,
  input  logic [1:0]                      lk_kind,
  input  logic                            fill_valid,
  input  logic [VA_W-OFF_W-1:0]           fill_vpn,
  input  logic [PA_W-OFF_W+PTE_FLAGS-1:0] fill_pte,
  input  logic                            inv_valid,
  input  logic [VA_W-OFF_W-1:0]           inv_vpn,
  input  logic                            flush,
  output logic                            rsp_valid,
  output logic                            rsp_miss,
  output logic                            rsp_fault,
  output logic [PA_W-1:0]                 rsp_paddr
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]     lk_vpn;
  logic [VPN_W-1:0]     mnt_vpn;
  logic                 inv_en;
  logic                 wr_en;
  logic [IDX_W-1:0]     wr_idx;
  logic [IDX_W-1:0]     victim;
  logic [ENTRIES-1:0]   lk_match;
  logic [ENTRIES-1:0]   mnt_match;
  logic [ENTRIES-1:0]   occ;
  logic [ENTRIES-1:0]   touch;
  logic [ENTRIES-1:0]   clr;
  logic [IDX_W-1:0]     lk_idx;
  logic [IDX_W-1:0]     mnt_idx;
  logic [PTE_FLAGS-1:0] lk_flags;
  logic                 hit_any;
  logic                 allowed;
  logic [PFN_W-1:0]     pfn_rd;

  logic                 valid_q;
  logic                 miss_q;
  logic                 fault_q;
  logic                 ok_q;
  logic [OFF_W-1:0]     off_q;

  assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
  assign inv_en  = inv_valid && !flush;
  assign wr_en   = fill_valid && !flush && !inv_valid;
  assign mnt_vpn = inv_valid ? inv_vpn : fill_vpn;
  assign wr_idx  = (|mnt_match) ? mnt_idx : victim;
  assign hit_any = |lk_match;
  assign allowed = perm_ok(lk_flags, acc_kind_e'(lk_kind));

  assign touch = (lk_valid ? lk_match : '0)
               | (wr_en ? (ENTRIES'(1) << wr_idx) : '0);
  assign clr   = flush ? '1 : (inv_en ? mnt_match : '0);

  xlat_tlb_tags #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .IDX_W   (IDX_W),
    .FLG_W   (PTE_FLAGS)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_vpn    (lk_vpn),
    .mnt_vpn   (mnt_vpn),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_vpn    (fill_vpn),
    .wr_flags  (fill_pte[PTE_FLAGS-1:0]),
    .inv_en    (inv_en),
    .flush     (flush),
    .lk_match  (lk_match),
    .lk_idx    (lk_idx),
    .lk_flags  (lk_flags),
    .mnt_match (mnt_match),
    .mnt_idx   (mnt_idx),
    .occ       (occ)
  );

  xlat_tlb_nru #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_nru (
    .clk    (clk),
    .rst    (rst),
    .occ    (occ),
    .touch  (touch),
    .clr    (clr),
    .victim (victim)
  );

  xlat_tlb_pfn_ram #(
    .DEPTH (ENTRIES),
    .W     (PFN_W),
    .IDX_W (IDX_W)
  ) u_pfn (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (fill_pte[PFN_W+PTE_FLAGS-1:PTE_FLAGS]),
    .raddr (lk_idx),
    .rdata (pfn_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
      ok_q    <= 1'b0;
      off_q   <= '0;
    end else begin
      valid_q <= lk_valid;
      miss_q  <= lk_valid && !hit_any;
      fault_q <= lk_valid && hit_any && !allowed;
      ok_q    <= lk_valid && hit_any && allowed;
      off_q   <= lk_vaddr[OFF_W-1:0];
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_miss  = miss_q;
  assign rsp_fault = fault_q;
  assign rsp_paddr = ok_q ? {pfn_rd, off_q} : '0;

  // R1: every lookup is answered on the following cycle
  p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  // R1: no response flags without a request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_valid && !rsp_miss && !rsp_fault));

  // R8: a lookup right after a flush always misses
  p_empty_after_flush_r8: assert property (@(posedge clk) disable iff (rst)
    flush ##1 lk_valid |=> rsp_miss);

endmodule

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int OFF  = 12;
  localparam int VPNW = VA_W - OFF;
  localparam int PFNW = PA_W - OFF;
  localparam int PTEW = PFNW + 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            lk_valid = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [1:0]      lk_kind = '0;
  logic            fill_valid = 1'b0;
  logic [VPNW-1:0] fill_vpn = '0;
  logic [PTEW-1:0] fill_pte = '0;
  logic            inv_valid = 1'b0;
  logic [VPNW-1:0] inv_vpn = '0;
  logic            flush = 1'b0;
  logic            rsp_valid, rsp_miss, rsp_fault;
  logic [PA_W-1:0] rsp_paddr;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  logic [N-1:0]    m_vld, m_ref;
  logic [VPNW-1:0] m_vpn [N];
  logic [PTEW-1:0] m_pte [N];
  logic [31:0]     seed = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_tlb #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF), .ENTRIES(N)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // One cycle of stimulus; the model applies the lookup to the old contents first.
  task automatic step(input bit lv, input logic [31:0] va, input logic [1:0] k,
                      input bit fv, input logic [VPNW-1:0] fvpn, input logic [PTEW-1:0] fpte,
                      input bit iv, input logic [VPNW-1:0] ivpn, input bit fl, input string tag);
    bit found, ok, dup;
    int idx, widx;
    logic [3:0] f;
    logic [N-1:0] t, clr, nxt;
    logic e_miss, e_fault;
    logic [31:0] e_pa;
    string req;
    lk_valid = lv; lk_vaddr = va; lk_kind = k;
    fill_valid = fv; fill_vpn = fvpn; fill_pte = fpte;
    inv_valid = iv; inv_vpn = ivpn; flush = fl;
    found = 0; idx = 0;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == va[31:OFF]) begin found = 1; idx = i; end
    f = found ? m_pte[idx][3:0] : 4'h0;
    case (k)
      2'd0: ok = f[1];
      2'd1: ok = f[2];
      2'd2: ok = f[3];
      default: ok = 0;
    endcase
    ok = ok & f[0];
    e_miss  = !found;
    e_fault = found && !ok;
    e_pa    = (found && ok) ? {m_pte[idx][PTEW-1:4], va[OFF-1:0]} : 32'h0;
    t = '0;
    if (lv && found) t[idx] = 1'b1;
    clr = '0;
    if (fl) clr = '1;
    else if (iv) begin
      for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == ivpn) clr[i] = 1'b1;
    end else if (fv) begin
      dup = 0; widx = 0;
      for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == fvpn) begin dup = 1; widx = i; end
      if (!dup) begin
        bit got;
        got = 0;
        for (int i = 0; i < N; i++) if (!got && !m_vld[i]) begin got = 1; widx = i; end
        for (int i = 0; i < N; i++) if (!got && !m_ref[i]) begin got = 1; widx = i; end
      end
      m_vld[widx] = 1'b1; m_vpn[widx] = fvpn; m_pte[widx] = fpte; t[widx] = 1'b1;
    end
    m_vld = m_vld & ~clr;
    nxt = (m_ref | t) & ~clr;
    if (&nxt) nxt = t & ~clr;
    m_ref = nxt;
    @(negedge clk);
    chk("R1", {31'b0, rsp_valid}, {31'b0, lv});
    if (lv) begin
      if (tag != "") req = tag;
      else req = e_miss ? "R4" : (e_fault ? "R3" : "R2");
      chk(req, {31'b0, rsp_miss}, {31'b0, e_miss});
      chk(req, {31'b0, rsp_fault}, {31'b0, e_fault});
      chk(req, rsp_paddr, e_pa);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k, input string tag);
    step(1, va, k, 0, '0, '0, 0, '0, 0, tag);
  endtask

  task automatic fill(input logic [VPNW-1:0] v, input logic [PFNW-1:0] p, input logic [3:0] fl4);
    step(0, '0, 0, 1, v, {p, fl4}, 0, '0, 0, "");
  endtask

  initial begin
    m_vld = '0; m_ref = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R13", {31'b0, rsp_valid}, 32'h0);
    look(32'h0040_0123, 0, "R13");
    // R5 / R2: refill then translate
    fill(20'h12345, 20'hABCDE, 4'hF);
    look(32'h1234_5678, 0, "R5");
    chk("R2", rsp_paddr, 32'hABCD_E678);
    // R3: read-only page, every access kind
    fill(20'h00777, 20'h00042, 4'b0011);
    look(32'h0077_7001, 0, "R3");
    look(32'h0077_7002, 1, "R3");
    look(32'h0077_7003, 2, "R3");
    look(32'h0077_7004, 3, "R3");
    fill(20'h00888, 20'h00043, 4'b1110);
    look(32'h0088_8000, 0, "R3");
    // R10: lookup in the cycle of the refill sees old contents
    step(1, 32'h0099_9abc, 0, 1, 20'h00999, {20'h00055, 4'hF}, 0, '0, 0, "R10");
    look(32'h0099_9abc, 0, "R10");
    // R6: duplicate refill overwrites in place
    fill(20'h00999, 20'h00066, 4'h3);
    look(32'h0099_9abc, 0, "R6");
    look(32'h0099_9abc, 1, "R6");
    // R9: refill with invalidate is dropped, invalidate wins
    step(0, '0, 0, 1, 20'h00AAA, {20'h1, 4'hF}, 1, 20'h00999, 0, "");
    look(32'h00AA_A000, 0, "R9");
    look(32'h0099_9000, 0, "R7");
    look(32'h1234_5000, 0, "R7");
    // R7: invalidate of an uncached page changes nothing
    step(0, '0, 0, 0, '0, '0, 1, 20'h0BEEF, 0, "");
    look(32'h1234_5001, 2, "R7");
    // R9: flush beats refill; R10 lookup still sees old contents
    step(1, 32'h1234_5002, 0, 1, 20'h00BBB, {20'h2, 4'hF}, 0, '0, 1, "R10");
    look(32'h00BB_B000, 0, "R9");
    look(32'h1234_5000, 0, "R8");
    // R11 / R12: fill empty buffer, then overflow
    for (int i = 0; i < N; i++) fill(VPNW'(20'h00100 + i), PFNW'(20'h00200 + i), 4'hF);
    for (int i = 0; i < N; i++) look({VPNW'(20'h00100 + i), 12'h010}, 0, "R11");
    fill(20'h00300, 20'h00400, 4'hF);
    for (int i = 0; i < N; i++) look({VPNW'(20'h00100 + i), 12'h020}, 0, "R12");
    look(32'h0030_0000, 0, "R12");
    fill(20'h00301, 20'h00401, 4'hF);
    for (int i = 0; i < N; i++) look({VPNW'(20'h00100 + i), 12'h030}, 0, "R12");
    look(32'h0030_1000, 0, "R12");
    // Sweep: six pages contend for four slots with mixed same-cycle operations
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      a = rnd(); b = rnd();
      step(a[1:0] != 0, {VPNW'(20'h00500 + (a[4:2] % 6)), b[11:0]}, a[6:5],
           a[9:7] < 2, VPNW'(20'h00500 + (a[12:10] % 6)), {8'h0, b[23:12], a[16:13]},
           a[19:17] == 0, VPNW'(20'h00500 + (a[22:20] % 6)), a[27:23] == 0, "");
    end
    step(0, '0, 0, 0, '0, '0, 0, '0, 0, "");
    summary();
    $finish;
  end

endmodule